// File: doc/BRIEF.md
# Shared-Bus Register Datapath Sequencer

This block is an 8-bit datapath built around one internal bus. Four general registers, an operand holding register (TMP) and an accumulator (ACC) all sit on that bus. Each storage element has two controls. A capture control loads the bus value at the clock edge. A drive control puts the element's contents onto the bus. An element that is not driving outputs all zeros, so the bus is simply the bitwise OR of every element's output.

The ALU takes its A operand from the bus and its B operand from TMP. Its result can only be written into ACC, and ACC's contents can only leave through the bus. Because of this, every register-to-register operation needs a fixed three-step sequence, which a small stepper runs:

1. Move the first source into TMP.
2. Put the second source on the bus and capture the ALU result in ACC.
3. Move ACC into the destination register.

A command consists of two source selectors, a destination selector, an operation code and a start strobe. The block answers with a busy level and a one-cycle done pulse. The register contents are exposed at the ports so that they can be checked.

Top module: `busreg_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all general registers, TMP and ACC, returns the stepper to idle, and holds `done` low. This also applies when the reset arrives in the middle of a sequence.
- R2: The command fields are latched when `start` is sampled high while idle. `busy` is then high for exactly three cycles. `done` is high in the cycle after the third step, which is the fourth clock edge counting the edge that sampled `start`.
- R3: In step 1, the register selected by `src_a` drives the bus and TMP captures it.
- R4: In step 2, the register selected by `src_b` drives the bus, and ACC captures the ALU result computed with A = bus and B = TMP. ACC changes in no other step.
- R5: In step 3, ACC drives the bus and the register selected by `dst` captures it. No other general register changes during the sequence.
- R6: Two-operand codes: `000` is A+B modulo 256 with the carry discarded, `100` is A AND B, `101` is A OR B, `110` is A XOR B.
- R7: One-operand codes act on A (the `src_b` register) only. `001` shifts left by one with a zero fill, `010` shifts right by one with a zero fill, and `011` inverts. The unused code `111` yields zero.
- R8: The bus is the OR of all element outputs. At most one element drives it in any cycle, and it is all zeros while idle.
- R9: A `start` sampled while busy is ignored: it changes neither the running command nor the number of done pulses.
- R10: `done` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a sequence when idle |
| src_a | input | 2 | Register moved into TMP (ALU operand B) |
| src_b | input | 2 | Register placed on the bus in step 2 (ALU operand A) |
| dst | input | 2 | Register receiving the result |
| op | input | 3 | ALU operation code |
| busy | output | 1 | High while a step is running |
| done | output | 1 | One-cycle completion pulse |
| reg_file | output | 32 | General registers, R0 in bits 7:0 up to R3 in bits 31:24 |
| tmp_val | output | 8 | TMP contents |
| acc_val | output | 8 | ACC contents |

## Verification
The bench builds the block with its defaults: 8-bit data and four general registers. With only four selectors, random commands often pick the same register for both sources and the destination. This exercises the ordering of the three captures, since TMP has to take its value before the destination is overwritten.

Because reset leaves every register at zero, the bench first creates data with inversions and shifts. It then checks the result, TMP and ACC against its own model after every done pulse. It also checks that starts issued mid-sequence and resets issued mid-sequence behave as required.

// File: rtl/srd_pkg.sv
package srd_pkg;

  typedef enum logic [1:0] {
    STEP_IDLE  = 2'd0,
    STEP_ONE   = 2'd1,
    STEP_TWO   = 2'd2,
    STEP_THREE = 2'd3
  } step_t;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SHL  = 3'b001,
    OP_SHR  = 3'b010,
    OP_NOT  = 3'b011,
    OP_AND  = 3'b100,
    OP_OR   = 3'b101,
    OP_XOR  = 3'b110,
    OP_NONE = 3'b111
  } alu_op_t;

endpackage

// File: rtl/srd_reg.sv
module srd_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] drv
);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (set) q <= d;
  end

  // A storage element that is not driving contributes zeros to the OR bus.
  assign drv = en ? q : '0;

endmodule

// File: rtl/srd_alu.sv
module srd_alu #(
  parameter int W = 8
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  import srd_pkg::*;

  function automatic logic [W-1:0] alu_eval(input logic [2:0] code,
                                            input logic [W-1:0] x,
                                            input logic [W-1:0] z);
    logic [W-1:0] r;
    case (alu_op_t'(code))
      OP_ADD:  r = x + z;                 // carry out dropped by width
      OP_SHL:  r = x << 1;
      OP_SHR:  r = x >> 1;
      OP_NOT:  r = ~x;
      OP_AND:  r = x & z;
      OP_OR:   r = x | z;
      OP_XOR:  r = x ^ z;
      default: r = '0;
    endcase
    return r;
  endfunction

  assign y = alu_eval(op, a, b);

endmodule

// File: rtl/srd_stepper.sv
module srd_stepper #(
  parameter int NUM_REGS = 4,
  localparam int SEL_W   = $clog2(NUM_REGS),
  localparam int NSLOT   = NUM_REGS + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SEL_W-1:0] src_a,
  input  logic [SEL_W-1:0] src_b,
  input  logic [SEL_W-1:0] dst,
  input  logic [2:0]       op,
  output srd_pkg::step_t   step,
  output logic [NSLOT-1:0] en_vec,
  output logic [NSLOT-1:0] set_vec,
  output logic [2:0]       alu_op,
  output logic             busy,
  output logic             done
);
  import srd_pkg::*;

  localparam int TMP_IDX = NUM_REGS;
  localparam int ACC_IDX = NUM_REGS + 1;

  logic [SEL_W-1:0] a_q, b_q, d_q;
  logic [2:0]       op_q;
  logic             take_cmd;

  assign take_cmd = (step == STEP_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= STEP_IDLE;
      done <= 1'b0;
      a_q  <= '0;
      b_q  <= '0;
      d_q  <= '0;
      op_q <= '0;
    end else begin
      done <= (step == STEP_THREE);
      if (take_cmd) begin
        a_q  <= src_a;
        b_q  <= src_b;
        d_q  <= dst;
        op_q <= op;
      end
      case (step)
        STEP_IDLE:  if (start) step <= STEP_ONE;
        STEP_ONE:   step <= STEP_TWO;
        STEP_TWO:   step <= STEP_THREE;
        default:    step <= STEP_IDLE;
      endcase
    end
  end

  // Per-step decode: exactly one driver and one capturer per active step.
  always_comb begin
    en_vec  = '0;
    set_vec = '0;
    case (step)
      STEP_ONE: begin
        en_vec[a_q]      = 1'b1;
        set_vec[TMP_IDX] = 1'b1;
      end
      STEP_TWO: begin
        en_vec[b_q]      = 1'b1;
        set_vec[ACC_IDX] = 1'b1;
      end
      STEP_THREE: begin
        en_vec[ACC_IDX]  = 1'b1;
        set_vec[d_q]     = 1'b1;
      end
      default: ;
    endcase
  end

  assign alu_op = op_q;
  assign busy   = (step != STEP_IDLE);

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_ignore_start_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable({a_q, b_q, d_q, op_q}));

  p_done_after_three_r2: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_THREE) |=> (done && step == STEP_IDLE));

  p_step_order_r2: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_ONE) |=> (step == STEP_TWO));

endmodule

// File: rtl/busreg_sequencer.sv
module busreg_sequencer #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [SEL_W-1:0]           src_a,
  input  logic [SEL_W-1:0]           src_b,
  input  logic [SEL_W-1:0]           dst,
  input  logic [2:0]                 op,
  output logic                       busy,
  output logic                       done,
  output logic [NUM_REGS*DATA_W-1:0] reg_file,
  output logic [DATA_W-1:0]          tmp_val,
  output logic [DATA_W-1:0]          acc_val
);
  import srd_pkg::*;

  localparam int NSLOT   = NUM_REGS + 2;
  localparam int TMP_IDX = NUM_REGS;
  localparam int ACC_IDX = NUM_REGS + 1;

  step_t             step;
  logic [NSLOT-1:0]  en_vec, set_vec;
  logic [2:0]        alu_op;
  logic [DATA_W-1:0] slot_q   [NSLOT];
  logic [DATA_W-1:0] slot_drv [NSLOT];
  logic [DATA_W-1:0] slot_d   [NSLOT];
  logic [DATA_W-1:0] bus;
  logic [DATA_W-1:0] alu_y;

  srd_stepper #(.NUM_REGS(NUM_REGS)) u_step (
    .clk(clk), .rst(rst), .start(start),
    .src_a(src_a), .src_b(src_b), .dst(dst), .op(op),
    .step(step), .en_vec(en_vec), .set_vec(set_vec),
    .alu_op(alu_op), .busy(busy), .done(done)
  );

  // Slots 0..NUM_REGS-1 are general registers, then TMP, then ACC.
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (i == ACC_IDX) begin : g_acc_in
      assign slot_d[i] = alu_y;      // result path lands only in ACC
    end else begin : g_bus_in
      assign slot_d[i] = bus;
    end
    srd_reg #(.W(DATA_W)) u_reg (
      .clk(clk), .rst(rst), .set(set_vec[i]), .en(en_vec[i]),
      .d(slot_d[i]), .q(slot_q[i]), .drv(slot_drv[i])
    );
  end

  // Wired-OR bus.
  always_comb begin
    bus = '0;
    for (int k = 0; k < NSLOT; k++) bus = bus | slot_drv[k];
  end

  srd_alu #(.W(DATA_W)) u_alu (
    .op(alu_op), .a(bus), .b(slot_q[TMP_IDX]), .y(alu_y)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_out
    assign reg_file[i*DATA_W +: DATA_W] = slot_q[i];
  end
  assign tmp_val = slot_q[TMP_IDX];
  assign acc_val = slot_q[ACC_IDX];

  p_one_driver_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(en_vec));

  p_idle_bus_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (bus == '0));

  p_tmp_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_ONE) |=> (tmp_val == $past(bus)));

  p_acc_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_TWO) |=> (acc_val == $past(alu_y)));

  p_acc_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (step != STEP_TWO) |=> $stable(acc_val));

  p_regs_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (step != STEP_THREE) |=> $stable(reg_file));

endmodule

// File: tb/busreg_sequencer_test.sv
module busreg_sequencer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  src_a = '0, src_b = '0, dst = '0;
  logic [2:0]  op = '0;
  logic        busy, done;
  logic [31:0] reg_file;
  logic [7:0]  tmp_val, acc_val;

  busreg_sequencer uut (
    .clk(clk), .rst(rst), .start(start), .src_a(src_a), .src_b(src_b),
    .dst(dst), .op(op), .busy(busy), .done(done), .reg_file(reg_file),
    .tmp_val(tmp_val), .acc_val(acc_val)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] regs;
    logic [7:0]  tmp;
    logic [7:0]  acc;
    string       req;
  } exp_t;

  exp_t       sb[$];
  logic [7:0] mdl [4];
  int         n_cmp = 0, n_bad = 0;
  bit         finished = 1'b0;
  bit         prev_done = 1'b0;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference ALU: A is the src_b register, B is the src_a register (via TMP).
  function automatic logic [7:0] ref_alu(input logic [2:0] c,
                                         input logic [7:0] a, input logic [7:0] b);
    logic [8:0] wide;
    if (c == 3'b000) begin wide = {1'b0, a} + {1'b0, b}; return wide[7:0]; end
    if (c == 3'b001) return {a[6:0], 1'b0};
    if (c == 3'b010) return {1'b0, a[7:1]};
    if (c == 3'b011) return a ^ 8'hFF;
    if (c == 3'b100) return a & b;
    if (c == 3'b101) return a | b;
    if (c == 3'b110) return a ^ b;
    return 8'h00;
  endfunction

  // Monitor: pops one expected item per done pulse.
  always @(negedge clk) begin
    if (!rst) begin
      if (done && prev_done) check(1'b0, "R10 done held two cycles", 1, 0);
      if (done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9 unexpected extra done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(reg_file == e.regs, {"R5 ", e.req, " reg file"}, reg_file, e.regs);
          check(tmp_val == e.tmp, "R3 TMP holds src_a", {24'h0, tmp_val}, {24'h0, e.tmp});
          check(acc_val == e.acc, {"R4 ", e.req, " ACC"}, {24'h0, acc_val}, {24'h0, e.acc});
        end
      end
      prev_done = done;
    end else begin
      prev_done = 1'b0;
    end
  end

  // Driver: predicts, pushes, then runs one command; noisy adds starts while busy.
  task automatic issue(input logic [1:0] a, input logic [1:0] b, input logic [1:0] d,
                       input logic [2:0] c, input string req, input bit noisy);
    exp_t e;
    logic [7:0] res;
    int cnt;
    res   = ref_alu(c, mdl[b], mdl[a]);
    e.tmp = mdl[a];
    e.acc = res;
    mdl[d] = res;
    e.regs = {mdl[3], mdl[2], mdl[1], mdl[0]};
    e.req  = req;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b1; src_a = a; src_b = b; dst = d; op = c;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) check(busy == 1'b1, "R2 busy after start", {31'h0, busy}, 1);
      if (noisy && cnt < 3) begin
        start = 1'b1; src_a = ~a; src_b = ~b; dst = ~d; op = ~c;
      end else begin
        start = 1'b0;
      end
    end while (!done && cnt < 20);
    start = 1'b0;
    check(cnt == 4, "R2 done latency", cnt, 4);
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R9 R10 quiet after done",
          {30'h0, busy, done}, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(reg_file == 32'h0, "R1 regs cleared", reg_file, 0);
    check({tmp_val, acc_val} == 16'h0, "R1 TMP ACC cleared", {16'h0, tmp_val, acc_val}, 0);
    check(busy == 1'b0 && done == 1'b0, "R1 idle", {30'h0, busy, done}, 0);

    issue(2'd0, 2'd0, 2'd1, 3'b011, "R7 NOT", 1'b0);   // R1 = FF
    issue(2'd1, 2'd1, 2'd2, 3'b000, "R6 ADD carry dropped", 1'b0); // R2 = FE
    issue(2'd0, 2'd2, 2'd3, 3'b010, "R7 SHR", 1'b0);   // R3 = 7F
    issue(2'd1, 2'd3, 2'd0, 3'b001, "R7 SHL", 1'b0);   // R0 = FE
    // R8: distinct sources in steps 1 and 2; an overlapping driver would corrupt these
    issue(2'd3, 2'd0, 2'd2, 3'b100, "R6 R8 AND", 1'b0);
    issue(2'd3, 2'd0, 2'd1, 3'b110, "R6 R8 XOR", 1'b0);
    issue(2'd2, 2'd3, 2'd1, 3'b101, "R6 OR", 1'b0);
    issue(2'd1, 2'd1, 2'd3, 3'b111, "R7 unused code zero", 1'b0);
    issue(2'd2, 2'd2, 2'd2, 3'b000, "R6 aliased src dst", 1'b0);
    issue(2'd0, 2'd1, 2'd3, 3'b110, "R9 starts while busy", 1'b1);
    issue(2'd2, 2'd0, 2'd1, 3'b011, "R9 starts while busy", 1'b1);

    for (int n = 0; n < 40; n++) begin
      logic [1:0] ra, rb, rd;
      logic [2:0] rc;
      ra = 2'($urandom_range(3)); rb = 2'($urandom_range(3));
      rd = 2'($urandom_range(3)); rc = 3'($urandom_range(7));
      issue(ra, rb, rd, rc, "R6 R7 random", n[0]);
    end

    // R1: reset in the middle of a sequence
    @(negedge clk);
    start = 1'b1; src_a = 2'd1; src_b = 2'd2; dst = 2'd0; op = 3'b000;
    @(negedge clk); start = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
    check(reg_file == 32'h0 && tmp_val == 8'h0 && acc_val == 8'h0,
          "R1 mid-sequence reset clears", reg_file, 0);
    check(busy == 1'b0 && done == 1'b0, "R1 stepper idle after reset",
          {30'h0, busy, done}, 0);
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R1 no done after reset", {31'h0, done}, 0);
    check(sb.size() == 0, "R9 all expected items consumed", sb.size(), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule